// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps an SDRAM array alive by generating auto-refresh work at a steady pace derived from the retention window and the number of refreshes that window needs. Each elapsed interval adds one refresh credit to a small debt counter. While credit is owed and the scheduler is idle, it raises a request toward the command arbiter. When the arbiter grants the command bus, the scheduler checks the all-banks-precharged status. If every bank is already closed, it issues the auto-refresh command straight away. Otherwise it first closes every bank with a precharge-all command and waits out the precharge time.

After the refresh command, the scheduler keeps a hold-off line high until the row cycle time has passed, so no activate can follow too early. Postponed refreshes accumulate as debt up to a fixed ceiling. Once the debt passes an urgency level, a second output tells the arbiter to put refresh ahead of host traffic.

The interval, the precharge wait and the row cycle wait are all computed from the clock period and the timing values given as parameters. The interval rounds down and the two waits round up to whole clocks.

Top module: `refresh_scheduler`

## Requirements
- R1: One refresh credit is added every INTERVAL_CYC = floor(RETENTION_NS*1000 / (REFRESH_COUNT*CLK_PS)) clocks. The first credit lands on the INTERVAL_CYC-th rising edge after reset is released.
- R2: During and just after reset, the debt is zero, and refReq, refUrgent, actBlock and cmdA10 are low. cmdCsN, cmdRasN, cmdCasN and cmdWeN are all high, which means deselect.
- R3: refReq is high exactly when the debt is non-zero and no refresh sequence is in progress. A grant while the debt is zero produces no command and leaves actBlock low.
- R4: If banksIdle is high in the cycle the grant is accepted, the refresh command appears in the very next cycle and no precharge is sent.
- R5: If banksIdle is low at acceptance, the next cycle carries precharge-all: cmdCsN=0, cmdRasN=0, cmdCasN=1, cmdWeN=0, cmdA10=1. The refresh command follows exactly TRP_CYC = ceil(TRP_PS/CLK_PS) cycles later, with deselect on the bus in between.
- R6: The refresh command is cmdCsN=0, cmdRasN=0, cmdCasN=0, cmdWeN=1 with cmdA10=0. Each refresh removes one credit from the debt.
- R7: actBlock is high from the first command of a sequence through the cycle before refresh+TRC_CYC, where TRC_CYC = ceil(TRC_PS/CLK_PS). It is low again in cycle refresh+TRC_CYC.
- R8: The debt never exceeds DEBT_MAX (8). A credit that arrives while the debt is full is dropped.
- R9: refUrgent is high exactly when the debt is greater than URGENT_LEVEL (4).
- R10: If a credit arrives on the same edge that a refresh retires one, the debt is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Arbiter hands the command bus to the scheduler |
| banksIdle | input | 1 | All banks are in the precharged state |
| refReq | output | 1 | Refresh work is owed and the scheduler is idle |
| refUrgent | output | 1 | Debt is above the urgency level, so refresh goes ahead of host accesses |
| actBlock | output | 1 | Refresh sequence owns the bus; no activate allowed |
| cmdCsN | output | 1 | Chip select, active low |
| cmdRasN | output | 1 | Row strobe, active low |
| cmdCasN | output | 1 | Column strobe, active low |
| cmdWeN | output | 1 | Write enable, active low |
| cmdA10 | output | 1 | Address bit 10; high selects all banks on precharge |

## Verification
The interval tick that adds a credit and the refresh that retires one can hit the debt counter on the same edge. The bench keeps its own cycle count from reset release, so it knows in advance which edge carries a tick. It raises the grant two cycles before that edge, which makes the refresh cycle end exactly on the tick. It then judges the result from refUrgent: right after the collision, and again after one more refresh with no tick in between. A lost credit or a lost retirement shifts the urgency threshold and shows up as a mismatch.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_PRE    = 3'd1,
    S_WAITRP = 3'd2,
    S_REF    = 3'd3,
    S_WAITRC = 3'd4
  } refStateE;

  // Strobes from control to datapath
  typedef struct packed {
    logic issuePre;   // precharge-all on the bus this cycle; loads the tRP wait
    logic issueRef;   // auto-refresh on the bus this cycle; loads the tRC wait, retires a credit
    logic countDown;  // a wait state is running
  } refStrobeS;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 2083,
  parameter int unsigned DEBT_MAX     = 8,
  parameter int unsigned URGENT_LEVEL = 4,
  parameter int unsigned TRP_CYC      = 3,
  parameter int unsigned TRC_CYC      = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  refStrobeS strb,
  output logic      debtPending,
  output logic      debtUrgent,
  output logic      waitDone,
  output logic      cmdCsN,
  output logic      cmdRasN,
  output logic      cmdCasN,
  output logic      cmdWeN,
  output logic      cmdA10
);

  localparam int unsigned CNT_W    = $clog2(INTERVAL_CYC + 1);
  localparam int unsigned DEBT_W   = $clog2(DEBT_MAX + 1);
  localparam int unsigned WAIT_MAX = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
  localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1);

  localparam logic [CNT_W-1:0]  RELOAD    = CNT_W'(INTERVAL_CYC - 1);
  localparam logic [DEBT_W-1:0] DEBT_FULL = DEBT_W'(DEBT_MAX);
  localparam logic [DEBT_W-1:0] URGENT_AT = DEBT_W'(URGENT_LEVEL);
  localparam logic [WAIT_W-1:0] RP_LOAD   = WAIT_W'(TRP_CYC - 1);
  localparam logic [WAIT_W-1:0] RC_LOAD   = WAIT_W'(TRC_CYC - 1);

  logic [CNT_W-1:0]  intCnt;
  logic [DEBT_W-1:0] debt;
  logic [WAIT_W-1:0] waitCnt;
  logic              tick;

  // Interval timer: one credit per expiry
  assign tick = (intCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)     intCnt <= RELOAD;
    else if (tick) intCnt <= RELOAD;
    else           intCnt <= intCnt - 1'b1;
  end

  // Debt counter, saturating at DEBT_MAX
  always_ff @(posedge clk) begin
    if (!rstN) begin
      debt <= '0;
    end else begin
      unique case ({tick, strb.issueRef})
        2'b10:   if (debt != DEBT_FULL) debt <= debt + 1'b1;
        2'b01:   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  assign debtPending = (debt != '0);
  assign debtUrgent  = (debt > URGENT_AT);

  // Shared wait timer for the tRP and tRC windows
  always_ff @(posedge clk) begin
    if (!rstN)                               waitCnt <= '0;
    else if (strb.issuePre)                  waitCnt <= RP_LOAD;
    else if (strb.issueRef)                  waitCnt <= RC_LOAD;
    else if (strb.countDown && waitCnt != 0) waitCnt <= waitCnt - 1'b1;
  end

  assign waitDone = (waitCnt <= WAIT_W'(1));

  // Command encoding
  always_comb begin
    {cmdCsN, cmdRasN, cmdCasN, cmdWeN, cmdA10} = 5'b11110;
    if (strb.issuePre)      {cmdCsN, cmdRasN, cmdCasN, cmdWeN, cmdA10} = 5'b00101;
    else if (strb.issueRef) {cmdCsN, cmdRasN, cmdCasN, cmdWeN, cmdA10} = 5'b00010;
  end

  // R1: interval counter restarts a full period after each credit
  p_tick_reload_r1: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (intCnt == RELOAD));

  // R6: a refresh never retires a credit that is not owed
  p_dec_nonempty_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueRef |-> (debt != '0));

  // R6 and R10: debt moves by at most one per edge
  p_debt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (debt == $past(debt)) || (debt == $past(debt) + 1'b1) || (debt == $past(debt) - 1'b1));

  // R8: a full debt stays at the ceiling when a credit arrives without a refresh
  p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (debt == DEBT_FULL && tick && !strb.issueRef) |=> (debt == DEBT_FULL));

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int unsigned TRP_CYC = 3,
  parameter int unsigned TRC_CYC = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refGrant,
  input  logic      banksIdle,
  input  logic      debtPending,
  input  logic      waitDone,
  output refStrobeS strb,
  output logic      refReq,
  output logic      actBlock
);

  localparam bit SKIP_RP = (TRP_CYC <= 1);
  localparam bit SKIP_RC = (TRC_CYC <= 1);

  refStateE state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      S_IDLE:   if (debtPending && refGrant) nextState = banksIdle ? S_REF : S_PRE;
      S_PRE: begin
        strb.issuePre = 1'b1;
        nextState     = SKIP_RP ? S_REF : S_WAITRP;
      end
      S_WAITRP: begin
        strb.countDown = 1'b1;
        if (waitDone) nextState = S_REF;
      end
      S_REF: begin
        strb.issueRef = 1'b1;
        nextState     = SKIP_RC ? S_IDLE : S_WAITRC;
      end
      S_WAITRC: begin
        strb.countDown = 1'b1;
        if (waitDone) nextState = S_IDLE;
      end
      default:  nextState = S_IDLE;
    endcase
  end

  assign refReq   = (state == S_IDLE) && debtPending;
  assign actBlock = (state != S_IDLE);

  // R4: a refresh follows either a bank close or an all-idle status
  p_ref_after_close_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueRef |-> (($past(state) != S_IDLE) || $past(banksIdle)));

  // R5: a precharge-all is followed by the wait or by the refresh
  p_pre_leads_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.issuePre |=> (state == S_WAITRP || state == S_REF));

  // R3: with nothing owed, the scheduler stays idle
  p_no_debt_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !debtPending) |=> (state == S_IDLE));

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int unsigned CLK_PS        = 7500,
  parameter int unsigned RETENTION_NS  = 64000000,
  parameter int unsigned REFRESH_COUNT = 4096,
  parameter int unsigned TRP_PS        = 20000,
  parameter int unsigned TRC_PS        = 65000,
  parameter int unsigned DEBT_MAX      = 8,
  parameter int unsigned URGENT_LEVEL  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  input  logic banksIdle,
  output logic refReq,
  output logic refUrgent,
  output logic actBlock,
  output logic cmdCsN,
  output logic cmdRasN,
  output logic cmdCasN,
  output logic cmdWeN,
  output logic cmdA10
);

  localparam longint unsigned INTERVAL_L =
    (longint'(RETENTION_NS) * 64'd1000) / (longint'(REFRESH_COUNT) * longint'(CLK_PS));
  localparam int unsigned INTERVAL_CYC = int'(INTERVAL_L);
  localparam int unsigned TRP_CYC      = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int unsigned TRC_CYC      = (TRC_PS + CLK_PS - 1) / CLK_PS;

  refStrobeS strb;
  logic      debtPending;
  logic      waitDone;

  refsched_ctrl #(
    .TRP_CYC(TRP_CYC),
    .TRC_CYC(TRC_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .banksIdle(banksIdle),
    .debtPending(debtPending), .waitDone(waitDone), .strb(strb),
    .refReq(refReq), .actBlock(actBlock)
  );

  refsched_dp #(
    .INTERVAL_CYC(INTERVAL_CYC), .DEBT_MAX(DEBT_MAX), .URGENT_LEVEL(URGENT_LEVEL),
    .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .debtPending(debtPending), .debtUrgent(refUrgent), .waitDone(waitDone),
    .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN), .cmdA10(cmdA10)
  );

  // R6: a refresh is never driven while address bit 10 is set
  p_ref_a10_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdCsN && !cmdCasN) |-> !cmdA10);

endmodule

// File: tb/refresh_scheduler_test.sv
module refresh_scheduler_test;

  localparam int INTERVAL = 40;
  localparam int TRP      = 3;
  localparam int TRC      = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic banksIdle = 1'b1;
  logic refReq, refUrgent, actBlock;
  logic cmdCsN, cmdRasN, cmdCasN, cmdWeN, cmdA10;

  int nTests = 0;
  int nFail  = 0;

  // Bench model of the credit timing, kept from the requirements
  int   mcnt = 0;
  int   mdebt = 0;
  logic refSeen = 1'b0;
  logic tickM;

  always #10 clk = ~clk;

  refresh_scheduler #(
    .CLK_PS(7500), .RETENTION_NS(1228800), .REFRESH_COUNT(4096),
    .TRP_PS(20000), .TRC_PS(65000), .DEBT_MAX(8), .URGENT_LEVEL(4)
  ) uut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .banksIdle(banksIdle),
    .refReq(refReq), .refUrgent(refUrgent), .actBlock(actBlock),
    .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN), .cmdA10(cmdA10)
  );

  function automatic logic isRef();
    return !cmdCsN && !cmdRasN && !cmdCasN && cmdWeN && !cmdA10;
  endfunction
  function automatic logic isPre();
    return !cmdCsN && !cmdRasN && cmdCasN && !cmdWeN && cmdA10;
  endfunction
  function automatic logic isDesel();
    return cmdCsN && cmdRasN && cmdCasN && cmdWeN;
  endfunction

  always @(negedge clk) refSeen <= isRef();

  always @(posedge clk) begin
    if (!rstN) begin
      mcnt  <= 0;
      mdebt <= 0;
    end else begin
      tickM = (mcnt == INTERVAL - 1);
      mcnt <= tickM ? 0 : mcnt + 1;
      if (tickM && !refSeen)      mdebt <= (mdebt == 8) ? 8 : mdebt + 1;
      else if (!tickM && refSeen) mdebt <= mdebt - 1;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitModel(input int target);
    for (int i = 0; i < 1000 && mdebt != target; i++) @(negedge clk);
  endtask

  task automatic waitBlockLow(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (actBlock && n < 50);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    checkEq("R2 refReq in reset", refReq, 0);
    checkEq("R2 refUrgent in reset", refUrgent, 0);
    checkEq("R2 actBlock in reset", actBlock, 0);
    checkEq("R2 deselect in reset", isDesel() && !cmdA10, 1);
    rstN = 1'b1;
  endtask

  task automatic t_interval();
    repeat (INTERVAL - 1) @(posedge clk);
    @(negedge clk);
    checkEq("R1 no request before interval", refReq, 0);
    @(posedge clk);
    @(negedge clk);
    checkEq("R1 request at interval end", refReq, 1);
  endtask

  task automatic t_ref_idle();
    int n;
    refGrant = 1'b1; banksIdle = 1'b1;
    @(negedge clk);
    checkEq("R4 refresh next cycle (R6 encoding)", isRef(), 1);
    checkEq("R7 actBlock on refresh", actBlock, 1);
    refGrant = 1'b0;
    waitBlockLow(n);
    checkEq("R7 activate hold-off cycles", n, TRC);
    checkEq("R6 debt retired, R3 request low", refReq, 0);
  endtask

  task automatic t_grant_no_debt();
    int bad = 0;
    refGrant = 1'b1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (!isDesel() || actBlock) bad++;
    end
    refGrant = 1'b0;
    checkEq("R3 grant without debt ignored", bad, 0);
  endtask

  task automatic t_ref_open();
    int n; int bad = 0;
    for (int i = 0; i < 100 && !refReq; i++) @(negedge clk);
    checkEq("R3 request for next credit", refReq, 1);
    banksIdle = 1'b0; refGrant = 1'b1;
    @(negedge clk);
    checkEq("R5 precharge-all with A10", isPre(), 1);
    refGrant = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!isRef() && !isDesel()) bad++;
    end while (!isRef() && n < 20);
    checkEq("R5 precharge to refresh cycles", n, TRP);
    checkEq("R5 deselect during precharge wait", bad, 0);
    waitBlockLow(n);
    checkEq("R7 hold-off after closing refresh", n, TRC);
    banksIdle = 1'b1;
  endtask

  task automatic t_urgent();
    waitModel(4);
    checkEq("R9 urgent low at debt 4", refUrgent, 0);
    checkEq("R3 request while owed", refReq, 1);
    waitModel(5);
    checkEq("R9 urgent high at debt 5", refUrgent, 1);
  endtask

  task automatic t_collide();
    for (int i = 0; i < 100 && mcnt != INTERVAL - 2; i++) @(negedge clk);
    refGrant = 1'b1;
    @(negedge clk);
    checkEq("R10 refresh in collision cycle", isRef(), 1);
    refGrant = 1'b0;
    @(negedge clk);
    checkEq("R10 debt unchanged by tick plus refresh (urgent)", refUrgent, 1);
    for (int i = 0; i < 50 && actBlock; i++) @(negedge clk);
    refGrant = 1'b1;
    for (int i = 0; i < 50 && !isRef(); i++) @(negedge clk);
    refGrant = 1'b0;
    @(negedge clk);
    checkEq("R10 one more refresh drops below urgency", refUrgent, 0);
  endtask

  task automatic t_saturate();
    int refs = 0;
    refGrant = 1'b0;
    waitModel(8);
    for (int i = 0; i < 2 * INTERVAL; i++) begin
      @(negedge clk);
      checkEq("R8 saturated debt urgency", refUrgent, (mdebt > 4) ? 1 : 0);
    end
    refGrant = 1'b1;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      if (isRef()) refs++;
      checkEq("R8 drain urgency vs owed", refUrgent, (mdebt > 4) ? 1 : 0);
      checkEq("R3 drain request vs owed", refReq, (mdebt != 0 && !actBlock) ? 1 : 0);
    end
    refGrant = 1'b0;
    checkEq("R8 refreshes issued during drain", refs > 8 ? 1 : 0, 1);
  endtask

  initial begin
    #4000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_interval();
    t_ref_idle();
    t_grant_no_debt();
    t_ref_open();
    t_urgent();
    t_collide();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule